// File: doc/BRIEF.md
# Adaptive LMS Noise Canceller

This block is a streaming adaptive FIR filter that strips narrowband interference, such as mains hum, out of a sampled biomedical signal. Each accepted input pair carries two samples. The primary sample is the noisy measurement. The reference sample is correlated with the interference. The filter passes the reference through 32 adjustable taps to build an estimate of the interference. It subtracts that estimate from the primary sample, and the difference is the cleaned output.

The tap weights are not fixed. On every accepted sample each weight moves by the least-mean-squares rule with a constant step of 0.01, so the filter follows drift in the interference. The datapath is fully parallel: all 32 products, the sum, the error and all 32 weight updates are evaluated in the cycle the sample arrives. Every value is signed fixed point with 32 bits, 30 of them fractional, and every rescaled result saturates instead of wrapping.

The state is a 31-stage reference delay line plus 32 weight registers. Results appear one clock after the input strobe.

Top module: `lms_noise_canceller`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the delay line, all weights, `est_out`, `err_out` and `out_valid` are cleared to zero. The first sample after reset therefore yields `est_out` = 0 and `err_out` = `prim_in`.
- R2: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high. Outputs are registered with a latency of one clock.
- R3: The estimate is y = sat32(sum over k=0..31 of sat32((w[k]·t[k]) >>> 30)). Tap vector t[0] is the reference sample that arrives with the strobe, and t[k] is the reference accepted k strobes earlier. Products are 64-bit, the shift is arithmetic (floor), and the sum is taken at full width before saturation.
- R4: The error is e = sat32(d − y), where d is the primary sample accepted with the same strobe. `err_out` presents e as the cleaned signal.
- R5: On each strobe every weight becomes sat32(w[k] + sat32((s·t[k]) >>> 30)), where s = sat32((10737418·e) >>> 30). The rule uses the e and t[k] of that same sample and the weights before the update.
- R6: Cycles with `in_valid` low leave the delay line, the weights, `est_out` and `err_out` unchanged. A stream with idle gaps gives the same results as the same stream without gaps.
- R7: Every rescaled or summed value saturates to the range [−2^31, 2^31−1] and never wraps. For example, d = −2^31 with y near +2.0 gives e = −2^31.
- R8: A reference tone with a period of 20 samples and amplitude 0.5, plus a primary made of a slow wave and 0.3 times a phase-shifted copy of the reference, converges. After 2500 samples, the mean square of the error minus the slow wave falls below 0.002.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies `ref_in` and `prim_in` this cycle |
| ref_in | input | 32 | Reference sample, signed Q2.30 |
| prim_in | input | 32 | Primary (noisy) sample, signed Q2.30 |
| out_valid | output | 1 | `est_out` and `err_out` hold a new result |
| est_out | output | 32 | Interference estimate y, signed Q2.30 |
| err_out | output | 32 | Cleaned output e, signed Q2.30 |

## Verification
Every result of this block is due exactly one rising edge after the strobe that carried its inputs, and a weight change first shows up in the estimate of the next strobe. The bench drives each input at a falling edge and samples the outputs 1 ns after the following rising edge. It compares them with a behavioural model that advances once per strobe, so idle cycles must show the previous values held. Convergence is judged from the sampled `err_out` over late windows of the run. The saturation cases are compared bit-exactly against the same model.

// File: rtl/lms_pkg.sv
// Package: lms_pkg
// Shared constants for the adaptive noise canceller. Sample format is
// signed fixed point, SAMPLE_W bits with FRAC_W fractional bits.
// Assumes: all blocks of the canceller take their defaults from here.
package lms_pkg;
    localparam int SAMPLE_W = 32;
    localparam int FRAC_W   = 30;
    localparam int NUM_TAPS = 32;
    // Step size 0.01 expressed in the sample format (0.01 * 2^30).
    localparam int STEP_MU  = 10737418;
endpackage

// File: rtl/lms_sat.sv
// Module: lms_sat
// Clamps a wide signed value into a narrower signed range.
// Assumes: IN_W >= OUT_W; pure combinational, no state.
module lms_sat #(
    parameter int IN_W  = 64,
    parameter int OUT_W = 32
) (
    input  logic signed [IN_W-1:0]  din,
    output logic signed [OUT_W-1:0] dout
);
    localparam logic signed [IN_W-1:0] MAXV =
        signed'({{(IN_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}});
    localparam logic signed [IN_W-1:0] MINV = ~MAXV;

    // Select the clamped or passed-through value.
    always_comb begin
        if (din > MAXV)
            dout = MAXV[OUT_W-1:0];
        else if (din < MINV)
            dout = MINV[OUT_W-1:0];
        else
            dout = din[OUT_W-1:0];
    end
endmodule

// File: rtl/lms_delay_line.sv
// Module: lms_delay_line
// Holds past reference samples and presents the full tap vector:
// tap 0 is the incoming sample, tap k the sample k strobes older.
// Assumes: shifts only when en is high; synchronous active-low reset.
module lms_delay_line #(
    parameter int DW   = lms_pkg::SAMPLE_W,
    parameter int TAPS = lms_pkg::NUM_TAPS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic [DW-1:0]            x_in,
    output logic [TAPS-1:0][DW-1:0]  taps
);
    localparam int STAGES = TAPS - 1;

    logic [STAGES-1:0][DW-1:0] stage_q;

    // Shift the newest sample in on each accepted strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (en) begin
            stage_q[0] <= x_in;
            for (int i = 1; i < STAGES; i++)
                stage_q[i] <= stage_q[i-1];
        end
    end

    // Expose the current sample followed by the stored history.
    always_comb begin
        taps[0] = x_in;
        for (int i = 1; i < TAPS; i++)
            taps[i] = stage_q[i-1];
    end
endmodule

// File: rtl/lms_tap.sv
// Module: lms_tap
// One adaptive tap: a weight register, its rescaled product with the
// tap sample, and the LMS update w += sat(step * x >>> FRAC).
// Assumes: step already carries mu * e; updates only when en is high.
module lms_tap #(
    parameter int DW   = lms_pkg::SAMPLE_W,
    parameter int FRAC = lms_pkg::FRAC_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [DW-1:0] x_k,
    input  logic signed [DW-1:0] step,
    output logic signed [DW-1:0] prod
);
    localparam int PW = 2 * DW;

    logic signed [DW-1:0] w_q;
    logic signed [PW-1:0] wx_full;
    logic signed [PW-1:0] wx_shift;
    logic signed [PW-1:0] sx_full;
    logic signed [PW-1:0] sx_shift;
    logic signed [DW-1:0] upd;
    logic signed [DW:0]   w_sum;
    logic signed [DW-1:0] w_next;

    // Rescaled weight-times-sample and update term.
    always_comb begin
        wx_full  = PW'(w_q) * PW'(x_k);
        wx_shift = wx_full >>> FRAC;
        sx_full  = PW'(step) * PW'(x_k);
        sx_shift = sx_full >>> FRAC;
        w_sum    = (DW+1)'(w_q) + (DW+1)'(upd);
    end

    lms_sat #(.IN_W(PW), .OUT_W(DW)) u_sat_prod (.din(wx_shift), .dout(prod));
    lms_sat #(.IN_W(PW), .OUT_W(DW)) u_sat_upd  (.din(sx_shift), .dout(upd));
    lms_sat #(.IN_W(DW+1), .OUT_W(DW)) u_sat_w  (.din(w_sum), .dout(w_next));

    // Commit the adapted weight on each accepted strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            w_q <= '0;
        else if (en)
            w_q <= w_next;
    end
endmodule

// File: rtl/lms_sum.sv
// Module: lms_sum
// Adds all tap products at full width, then clamps to sample width.
// Assumes: inputs are signed DW-bit values; purely combinational.
module lms_sum #(
    parameter int DW   = lms_pkg::SAMPLE_W,
    parameter int TAPS = lms_pkg::NUM_TAPS
) (
    input  logic [TAPS-1:0][DW-1:0] prods,
    output logic signed [DW-1:0]    total
);
    localparam int SUM_W = DW + $clog2(TAPS) + 1;

    logic signed [SUM_W-1:0] acc;

    // Sign-extend and accumulate every product.
    always_comb begin
        acc = '0;
        for (int i = 0; i < TAPS; i++)
            acc = acc + {{(SUM_W-DW){prods[i][DW-1]}}, prods[i]};
    end

    lms_sat #(.IN_W(SUM_W), .OUT_W(DW)) u_sat_sum (.din(acc), .dout(total));
endmodule

// File: rtl/lms_noise_canceller.sv
// Module: lms_noise_canceller
// Adaptive LMS FIR canceller. Per strobe: estimate y from the reference
// taps, error e = d - y, adapt every weight, register y and e.
// Assumes: fully parallel datapath, one-cycle output latency,
// synchronous active-low reset, saturating fixed-point arithmetic.
module lms_noise_canceller #(
    parameter int DW   = lms_pkg::SAMPLE_W,
    parameter int FRAC = lms_pkg::FRAC_W,
    parameter int TAPS = lms_pkg::NUM_TAPS,
    parameter int MU   = lms_pkg::STEP_MU
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] ref_in,
    input  logic [DW-1:0] prim_in,
    output logic          out_valid,
    output logic [DW-1:0] est_out,
    output logic [DW-1:0] err_out
);
    localparam int PW = 2 * DW;
    localparam logic signed [DW-1:0] MU_C = DW'(MU);

    logic [TAPS-1:0][DW-1:0] taps;
    logic [TAPS-1:0][DW-1:0] prods;
    logic signed [DW-1:0]    est_c;
    logic signed [DW:0]      diff_c;
    logic signed [DW-1:0]    err_c;
    logic signed [PW-1:0]    mu_full;
    logic signed [PW-1:0]    mu_shift;
    logic signed [DW-1:0]    step_c;

    lms_delay_line #(.DW(DW), .TAPS(TAPS)) u_dline (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (in_valid),
        .x_in  (ref_in),
        .taps  (taps)
    );

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        lms_tap #(.DW(DW), .FRAC(FRAC)) u_tap (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (in_valid),
            .x_k   (taps[k]),
            .step  (step_c),
            .prod  (prods[k])
        );
    end

    lms_sum #(.DW(DW), .TAPS(TAPS)) u_sum (
        .prods (prods),
        .total (est_c)
    );

    // Error against the primary sample and the scaled step mu * e.
    always_comb begin
        diff_c   = {prim_in[DW-1], prim_in} - {est_c[DW-1], est_c};
        mu_full  = PW'(MU_C) * PW'(err_c);
        mu_shift = mu_full >>> FRAC;
    end

    lms_sat #(.IN_W(DW+1), .OUT_W(DW)) u_sat_err  (.din(diff_c), .dout(err_c));
    lms_sat #(.IN_W(PW), .OUT_W(DW))   u_sat_step (.din(mu_shift), .dout(step_c));

    // Register results one clock after each accepted strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            est_out   <= '0;
            err_out   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                est_out <= est_c;
                err_out <= err_c;
            end
        end
    end
endmodule

// File: rtl/lms_checker.sv
// Module: lms_checker
// Port-level properties for lms_noise_canceller, attached by bind.
// Assumes: same clock and synchronous active-low reset as the block.
module lms_checker #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [DW-1:0] prim_in,
    input logic          out_valid,
    input logic [DW-1:0] est_out,
    input logic [DW-1:0] err_out
);
    localparam logic signed [DW:0] HI = signed'({2'b00, {(DW-1){1'b1}}});
    localparam logic signed [DW:0] LO = ~HI;

    function automatic logic [DW-1:0] clip_diff(input logic [DW-1:0] a,
                                                 input logic [DW-1:0] b);
        logic signed [DW:0] t;
        t = signed'({a[DW-1], a}) - signed'({b[DW-1], b});
        if (t > HI) return HI[DW-1:0];
        if (t < LO) return LO[DW-1:0];
        return t[DW-1:0];
    endfunction

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && est_out == '0 && err_out == '0)); // R1

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2

    AST_ERR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> err_out == clip_diff($past(prim_in), est_out)); // R4

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(est_out) && $stable(err_out))); // R6
endmodule

bind lms_noise_canceller lms_checker #(.DW(DW)) u_lms_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .prim_in   (prim_in),
    .out_valid (out_valid),
    .est_out   (est_out),
    .err_out   (err_out)
);

// File: tb/test_lms_noise_canceller.sv
module test_lms_noise_canceller;
    localparam int  NT   = 32;
    localparam real ONE  = 1073741824.0;
    localparam real PI   = 3.14159265358979;
    localparam longint SMAX = 64'sd2147483647;
    localparam longint SMIN = -64'sd2147483648;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] ref_in = '0;
    logic [31:0] prim_in = '0;
    logic        out_valid;
    logic [31:0] est_out;
    logic [31:0] err_out;

    int tests = 0;
    int fails = 0;

    longint mw [NT];
    longint mx [NT];
    longint exp_y = 0;
    longint exp_e = 0;
    int     sat_hits = 0;

    always #2.5 clk = ~clk;

    lms_noise_canceller i_lms_noise_canceller (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .ref_in(ref_in), .prim_in(prim_in),
        .out_valid(out_valid), .est_out(est_out), .err_out(err_out)
    );

    function automatic longint sat32(input longint v);
        if (v > SMAX) return SMAX;
        if (v < SMIN) return SMIN;
        return v;
    endfunction

    function automatic longint sx(input logic [31:0] v);
        return longint'(signed'(v));
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < NT; k++) begin
            mw[k] = 0;
            mx[k] = 0;
        end
        exp_y = 0;
        exp_e = 0;
    endtask

    // Behavioural model: one LMS iteration per accepted sample.
    task automatic model_step(input longint x, input longint d);
        longint acc, stp;
        for (int k = NT - 1; k > 0; k--) mx[k] = mx[k-1];
        mx[0] = x;
        acc = 0;
        for (int k = 0; k < NT; k++) acc += sat32((mw[k] * mx[k]) >>> 30);
        exp_y = sat32(acc);
        exp_e = sat32(d - exp_y);
        stp = sat32((64'sd10737418 * exp_e) >>> 30);
        for (int k = 0; k < NT; k++)
            mw[k] = sat32(mw[k] + sat32((stp * mx[k]) >>> 30));
    endtask

    // Drive one cycle, then compare outputs 1 ns after the capturing edge.
    task automatic cycle(input bit v, input longint x, input longint d);
        @(negedge clk);
        in_valid = v;
        ref_in   = 32'(x);
        prim_in  = 32'(d);
        if (v) model_step(x, d);
        @(posedge clk);
        #1;
        check(out_valid == v, "R2", "out_valid", longint'(out_valid), longint'(v));
        check(sx(est_out) == exp_y, v ? "R3" : "R6", "est_out", sx(est_out), exp_y);
        check(sx(err_out) == exp_e, v ? "R5" : "R6", "err_out", sx(err_out), exp_e);
        if (v && (exp_e == SMIN || exp_e == SMAX || exp_y == SMIN || exp_y == SMAX))
            sat_hits++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        #1;
        check(out_valid == 1'b0, "R1", "out_valid after reset", longint'(out_valid), 0);
        check(est_out == '0, "R1", "est_out after reset", sx(est_out), 0);
        check(err_out == '0, "R1", "err_out after reset", sx(err_out), 0);
    endtask

    initial begin
        real    resid, slow, acc_early, acc_late;
        longint xs, ds;
        model_reset();
        do_reset();

        // R1: first sample after reset sees zero weights, so e equals d.
        cycle(1'b1, 64'sd300000000, 64'sd123456789);
        check(exp_y == 0 && sx(err_out) == 64'sd123456789, "R1", "first err",
              sx(err_out), 64'sd123456789);
        do_reset();

        // R8/R6: tone cancellation with idle gaps every seventh sample.
        acc_early = 0.0;
        acc_late  = 0.0;
        for (int n = 0; n < 3000; n++) begin
            xs   = longint'($rtoi(0.5 * $sin(2.0 * PI * n / 20.0) * ONE));
            slow = 0.1 * $sin(2.0 * PI * n / 1000.0);
            ds   = longint'($rtoi((slow + 0.15 * $sin(2.0 * PI * n / 20.0 + 0.7)) * ONE));
            if (n % 7 == 3) cycle(1'b0, 64'sd555, 64'sd777);
            cycle(1'b1, xs, ds);
            resid = real'(sx(err_out)) / ONE - slow;
            if (n < 10) acc_early += resid * resid;
            if (n >= 2500) acc_late += resid * resid;
        end
        check(acc_early / 10.0 > 0.004, "R8", "early residual power x1e6",
              longint'($rtoi(acc_early / 10.0 * 1.0e6)), 4000);
        check(acc_late / 500.0 < 0.002, "R8", "late residual power x1e6",
              longint'($rtoi(acc_late / 500.0 * 1.0e6)), 2000);

        // R7: drive extremes so y and e clamp; compared bit-exactly each cycle.
        do_reset();
        sat_hits = 0;
        for (int n = 0; n < 80; n++) begin
            xs = (n % 2 == 0) ? SMAX : SMIN;
            ds = (n < 40) ? SMAX : SMIN;
            cycle(1'b1, xs, ds);
        end
        check(sat_hits > 0, "R7", "saturated results seen", sat_hits, 1);
        cycle(1'b0, 0, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule